// File: doc/BRIEF.md
# TLB Special-Register Access Unit

This block holds the banked special-register file that sits in front of a small software-managed TLB. Move-to and move-from special-register operations arrive as single-cycle access strobes carrying a register number and, for writes, a data word. Reads return data combinationally. Writes take effect on the clock edge of the strobe.

The active bank comes from the low two bits of a bank-select word. When the bank is 1 or 2, the MMU side effects apply, and each of those two banks owns its own TLB array of 4 sets by 16 entries. Writing the tlb-hi register also updates the fault-cause register. Writing the tlb-lo register commits a whole entry. The lo word of that entry comes from the written data and the hi word comes from the fault-cause register. If the entry being replaced was valid, the block sends a single-page invalidate toward an external translation cache. Reading a special register in bank 1 or 2 refreshes the tlb-hi and tlb-lo mirrors from the selected entry.

A separate PID check compares a proposed process ID with the current one and requests a flush of the current ID's entries when they differ.

Top module: `tlb_sreg_unit`

## Requirements
- R1: After reset the following hold. Every special register in every bank reads 0. Every TLB entry reads 0, so all entries are invalid. `inval_vld` and `pid_flush` are 0.
- R2: The bank is `bank_word[1:0]`, and the upper bits are ignored. There are 16 registers per bank, numbered 0 to 15 by `acc_sel`. The banks are separate storage. A plain write to register n of one bank is seen only in register n of that bank.
- R3: In bank 1 or 2, a write to register 6 (tlb-hi) stores the value in register 6 and also in register 3 (fault cause) of the same bank.
- R4: In bank 1 or 2, a write to register 5 (tlb-lo) commits one entry to TLB array (bank − 1). The set is bits [5:4] and the index is bits [3:0] of register 4 (TLB select) of that bank. The entry's lo word becomes the written data and its hi word becomes the current register 3 value.
- R5: When an R4 commit replaces an entry whose old lo bit 3 (valid) is 1, `inval_vld` is 1 for exactly the cycle after the strobe edge. In that cycle `inval_addr` = {old hi[31:13], 13'b0}. When the old valid bit is 0, `inval_vld` stays 0.
- R6: In bank 1 or 2, a read of register 5 returns the selected entry's lo word and a read of register 6 returns its hi word. The read strobe edge copies both words into the bank's registers 5 and 6.
- R7: A pulse on `pid_req` raises `pid_flush` in the next cycle only if `new_pid[7:0]` ≠ `cur_pid[7:0]`. In that cycle `pid_flush_id` = the `cur_pid[7:0]` that was sampled.
- R8: In bank 0 or 3, writes to registers 5 and 6 are plain stores. They commit no entry, raise no `inval_vld` and leave register 3 unchanged.
- R9: Reads do not modify register 3 or 4, or any register outside registers 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_word | input | 32 | Bank-select register; bits [1:0] pick the bank |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| acc_sel | input | 4 | Special-register number |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `bank_word`/`acc_sel` |
| pid_req | input | 1 | PID-change check strobe |
| cur_pid | input | 32 | Current process ID (low 8 bits used) |
| new_pid | input | 32 | Proposed process ID (low 8 bits used) |
| inval_vld | output | 1 | One-cycle single-page invalidate request |
| inval_addr | output | 32 | Page address to invalidate |
| pid_flush | output | 1 | One-cycle request to flush the current PID's entries |
| pid_flush_id | output | 8 | PID to be flushed |

## Verification
Each result has its own timing:
- `rdata` is combinational. The bench samples it a short delay after driving the read, before the clock edge.
- `inval_vld`/`inval_addr` and `pid_flush`/`pid_flush_id` are registered one stage after the strobe edge. The bench drops the strobe at the following falling edge and samples them there, inside the only cycle in which the pulse is valid.
- Register-file and TLB updates land on the strobe edge. They are checked by later reads, which also exercise the mirror refresh.

The bench drives the strobe for one cycle and waits a full extra cycle between accesses. This keeps each pulse tied to the access that caused it.

// File: rtl/tsr_pkg.sv
// Shared constants and types for the TLB special-register access unit.
// Assumes a 32-bit special-register word and four banks selected by 2 bits.
package tsr_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BANK_W    = 2;
    localparam int unsigned NBANKS    = 4;
    localparam int unsigned NTLB_ARR  = 2;
    // register numbers whose side effects are decoded
    localparam int unsigned REG_CAUSE = 3;
    localparam int unsigned REG_TSEL  = 4;
    localparam int unsigned REG_TLO   = 5;
    localparam int unsigned REG_THI   = 6;
    // valid bit position inside an entry's lo word
    localparam int unsigned LO_VALID_BIT = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } tlb_entry_t;

    // Banks 1 and 2 are the MMU banks that own a TLB array.
    function automatic logic is_tlb_bank(input logic [BANK_W-1:0] b);
        return (b == 2'd1) || (b == 2'd2);
    endfunction
endpackage

// File: rtl/tsr_regfile.sv
// Banked special-register file: NBANKS banks of NREG words.
// One primary write port, one fault-cause side write and one mirror
// pair write, all into the bank given by `bank`. Reads are combinational.
// Assumes the side writes never target the same word as the primary write
// in the same cycle (guaranteed by the control decode).
module tsr_regfile
    import tsr_pkg::*;
#(
    parameter  int unsigned NREG  = 16,
    localparam int unsigned SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  word_t             wr_data,
    input  logic              cause_en,
    input  logic              mir_en,
    input  word_t             mir_hi,
    input  word_t             mir_lo,
    input  logic [SEL_W-1:0]  rd_sel,
    output word_t             rd_data,
    output word_t             tsel_q,
    output word_t             cause_q
);
    localparam logic [SEL_W-1:0] S_CAUSE = SEL_W'(REG_CAUSE);
    localparam logic [SEL_W-1:0] S_TSEL  = SEL_W'(REG_TSEL);
    localparam logic [SEL_W-1:0] S_TLO   = SEL_W'(REG_TLO);
    localparam logic [SEL_W-1:0] S_THI   = SEL_W'(REG_THI);

    word_t mem [NBANKS][NREG];

    // Purpose: clear all banks on reset, else apply the enabled writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANKS; b++) begin
                for (int r = 0; r < NREG; r++) begin
                    mem[b][r] <= '0;
                end
            end
        end else begin
            if (wr_en)    mem[bank][wr_sel]  <= wr_data;
            if (cause_en) mem[bank][S_CAUSE] <= wr_data;
            if (mir_en) begin
                mem[bank][S_TLO] <= mir_lo;
                mem[bank][S_THI] <= mir_hi;
            end
        end
    end

    assign rd_data = mem[bank][rd_sel];
    assign tsel_q  = mem[bank][S_TSEL];
    assign cause_q = mem[bank][S_CAUSE];
endmodule

// File: rtl/tsr_tlb_array.sv
// TLB storage: NTLB_ARR independent arrays of SETS x WAYS entries.
// A single shared address (set, index) drives a combinational read of the
// chosen array and the synchronous write into it.
module tsr_tlb_array
    import tsr_pkg::*;
#(
    parameter  int unsigned SETS   = 4,
    parameter  int unsigned WAYS   = 16,
    localparam int unsigned SET_W  = $clog2(SETS),
    localparam int unsigned IDX_W  = $clog2(WAYS),
    localparam int unsigned ADDR_W = SET_W + IDX_W,
    localparam int unsigned DEPTH  = SETS * WAYS,
    localparam int unsigned ARR_W  = $clog2(NTLB_ARR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ARR_W-1:0] arr,
    input  logic [SET_W-1:0] set_sel,
    input  logic [IDX_W-1:0] idx_sel,
    input  logic             we,
    input  tlb_entry_t       wr_entry,
    output tlb_entry_t       rd_entry
);
    logic [ADDR_W-1:0] addr;
    tlb_entry_t        rd_per [NTLB_ARR];

    assign addr = {set_sel, idx_sel};

    for (genvar g = 0; g < NTLB_ARR; g++) begin : g_arr
        tlb_entry_t mem [DEPTH];

        // Purpose: zero this array on reset, else store a committed entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && (arr == ARR_W'(g))) begin
                mem[addr] <= wr_entry;
            end
        end

        assign rd_per[g] = mem[addr];
    end

    assign rd_entry = rd_per[arr];
endmodule

// File: rtl/tsr_side_fx.sv
// Access decode and MMU side effects. It turns an access strobe into
// register-file write enables, the cause side write, the TLB commit and
// the mirror refresh. It registers the single-page invalidate request for
// the entry being replaced.
// Assumes `old_entry` is the array word at the address derived from `tsel_q`.
module tsr_side_fx
    import tsr_pkg::*;
#(
    parameter  int unsigned NREG       = 16,
    parameter  int unsigned SETS       = 4,
    parameter  int unsigned WAYS       = 16,
    parameter  int unsigned PAGE_SHIFT = 13,
    localparam int unsigned SEL_W      = $clog2(NREG),
    localparam int unsigned SET_W      = $clog2(SETS),
    localparam int unsigned IDX_W      = $clog2(WAYS),
    localparam int unsigned VPN_W      = WORD_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [BANK_W-1:0] bank,
    input  logic [SEL_W-1:0]  sel,
    input  word_t             tsel_q,
    input  tlb_entry_t        old_entry,
    output logic              rf_wr_en,
    output logic              cause_en,
    output logic              mir_en,
    output logic              tlb_we,
    output logic [SET_W-1:0]  tlb_set,
    output logic [IDX_W-1:0]  tlb_idx,
    output logic              inval_vld,
    output word_t             inval_addr
);
    logic             mmu_bank;
    logic             wr_hit;
    logic             old_valid;
    logic [VPN_W-1:0] old_vpn;
    logic             unused_bits;

    // Purpose: decode which storage an access touches.
    always_comb begin
        mmu_bank = is_tlb_bank(bank);
        wr_hit   = acc_en && acc_wr;
        rf_wr_en = wr_hit;
        cause_en = wr_hit && mmu_bank && (sel == SEL_W'(REG_THI));
        tlb_we   = wr_hit && mmu_bank && (sel == SEL_W'(REG_TLO));
        mir_en   = acc_en && !acc_wr && mmu_bank;
    end

    assign tlb_idx   = tsel_q[IDX_W-1:0];
    assign tlb_set   = tsel_q[IDX_W+SET_W-1:IDX_W];
    assign old_valid = old_entry.lo[LO_VALID_BIT];
    assign old_vpn   = old_entry.hi[WORD_W-1:PAGE_SHIFT];

    assign unused_bits = ^{tsel_q[WORD_W-1:IDX_W+SET_W],
                           old_entry.hi[PAGE_SHIFT-1:0], old_entry.lo};

    // Purpose: pulse an invalidate for a valid entry that is being replaced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inval_vld  <= 1'b0;
            inval_addr <= '0;
        end else begin
            inval_vld <= tlb_we && old_valid;
            if (tlb_we && old_valid) begin
                inval_addr <= {old_vpn, {PAGE_SHIFT{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/tsr_pid_cmp.sv
// PID-change check: on a request, compares the low PID_W bits of the new and
// current process IDs and pulses a flush request for the current ID when
// they differ. Upper bits of both inputs are ignored.
module tsr_pid_cmp
    import tsr_pkg::*;
#(
    parameter int unsigned PID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  word_t            cur_pid,
    input  word_t            new_pid,
    output logic             flush,
    output logic [PID_W-1:0] flush_id
);
    logic differ;
    logic unused_hi;

    assign differ    = cur_pid[PID_W-1:0] != new_pid[PID_W-1:0];
    assign unused_hi = ^{cur_pid[WORD_W-1:PID_W], new_pid[WORD_W-1:PID_W]};

    // Purpose: register the flush pulse and the ID it applies to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush    <= 1'b0;
            flush_id <= '0;
        end else begin
            flush <= req && differ;
            if (req && differ) flush_id <= cur_pid[PID_W-1:0];
        end
    end
endmodule

// File: rtl/tlb_sreg_unit.sv
// Top of the TLB special-register access unit. Wires the banked register
// file, the two TLB arrays, the side-effect decode and the PID check.
// Read data is combinational. In banks 1 and 2 the tlb-lo/tlb-hi numbers
// read the selected entry, which is the value the mirrors take at the edge.
// Assumes one access per strobe cycle.
module tlb_sreg_unit
    import tsr_pkg::*;
#(
    parameter  int unsigned NREG       = 16,
    parameter  int unsigned SETS       = 4,
    parameter  int unsigned WAYS       = 16,
    parameter  int unsigned PAGE_SHIFT = 13,
    parameter  int unsigned PID_W      = 8,
    localparam int unsigned SEL_W      = $clog2(NREG),
    localparam int unsigned SET_W      = $clog2(SETS),
    localparam int unsigned IDX_W      = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      bank_word,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [SEL_W-1:0] acc_sel,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             pid_req,
    input  logic [31:0]      cur_pid,
    input  logic [31:0]      new_pid,
    output logic             inval_vld,
    output logic [31:0]      inval_addr,
    output logic             pid_flush,
    output logic [PID_W-1:0] pid_flush_id
);
    logic [BANK_W-1:0] bank;
    logic              unused_bank_hi;
    word_t             rf_rd, tsel_q, cause_q;
    logic              rf_wr_en, cause_en, mir_en, tlb_we;
    logic [SET_W-1:0]  tlb_set;
    logic [IDX_W-1:0]  tlb_idx;
    logic              tlb_arr;
    tlb_entry_t        cur_entry, new_entry;

    assign bank           = bank_word[BANK_W-1:0];
    assign unused_bank_hi = ^bank_word[31:BANK_W];
    // bank 1 -> array 0, bank 2 -> array 1 (bank minus one)
    assign tlb_arr        = bank[1];
    assign new_entry      = '{hi: cause_q, lo: wdata};

    tsr_regfile #(.NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank     (bank),
        .wr_en    (rf_wr_en),
        .wr_sel   (acc_sel),
        .wr_data  (wdata),
        .cause_en (cause_en),
        .mir_en   (mir_en),
        .mir_hi   (cur_entry.hi),
        .mir_lo   (cur_entry.lo),
        .rd_sel   (acc_sel),
        .rd_data  (rf_rd),
        .tsel_q   (tsel_q),
        .cause_q  (cause_q)
    );

    tsr_tlb_array #(.SETS(SETS), .WAYS(WAYS)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr      (tlb_arr),
        .set_sel  (tlb_set),
        .idx_sel  (tlb_idx),
        .we       (tlb_we),
        .wr_entry (new_entry),
        .rd_entry (cur_entry)
    );

    tsr_side_fx #(
        .NREG(NREG), .SETS(SETS), .WAYS(WAYS), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_fx (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_wr     (acc_wr),
        .bank       (bank),
        .sel        (acc_sel),
        .tsel_q     (tsel_q),
        .old_entry  (cur_entry),
        .rf_wr_en   (rf_wr_en),
        .cause_en   (cause_en),
        .mir_en     (mir_en),
        .tlb_we     (tlb_we),
        .tlb_set    (tlb_set),
        .tlb_idx    (tlb_idx),
        .inval_vld  (inval_vld),
        .inval_addr (inval_addr)
    );

    tsr_pid_cmp #(.PID_W(PID_W)) u_pid (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (pid_req),
        .cur_pid  (cur_pid),
        .new_pid  (new_pid),
        .flush    (pid_flush),
        .flush_id (pid_flush_id)
    );

    // Purpose: select register-file data or the live entry for the mirrors.
    always_comb begin
        rdata = rf_rd;
        if (is_tlb_bank(bank)) begin
            if (acc_sel == SEL_W'(REG_TLO)) rdata = cur_entry.lo;
            if (acc_sel == SEL_W'(REG_THI)) rdata = cur_entry.hi;
        end
    end
endmodule

// File: rtl/tsr_checker.sv
// Protocol checker for tlb_sreg_unit, attached by bind. It relates the
// output pulses to the strobes of the previous cycle.
module tsr_checker #(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned PID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      bank_word,
    input logic             acc_en,
    input logic             acc_wr,
    input logic [SEL_W-1:0] acc_sel,
    input logic             pid_req,
    input logic [31:0]      cur_pid,
    input logic [31:0]      new_pid,
    input logic             inval_vld,
    input logic             pid_flush,
    input logic [PID_W-1:0] pid_flush_id
);
    logic mmu_bank;
    logic pid_same;
    assign mmu_bank = (bank_word[1:0] == 2'd1) || (bank_word[1:0] == 2'd2);
    assign pid_same = cur_pid[PID_W-1:0] == new_pid[PID_W-1:0];

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!inval_vld && !pid_flush));

    a_r5_inval_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        inval_vld |-> $past(acc_en && acc_wr && mmu_bank && (acc_sel == SEL_W'(5))));

    a_r8_plain_bank_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !mmu_bank) |=> !inval_vld);

    a_r7_flush_needs_diff: assert property (@(posedge clk) disable iff (!rst_n)
        pid_flush |-> $past(pid_req && !pid_same));

    a_r7_equal_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (pid_req && pid_same) |=> !pid_flush);

    a_r7_flush_id: assert property (@(posedge clk) disable iff (!rst_n)
        pid_flush |-> (pid_flush_id == $past(cur_pid[PID_W-1:0])));
endmodule

bind tlb_sreg_unit tsr_checker #(.SEL_W(SEL_W), .PID_W(PID_W)) u_tsr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank_word    (bank_word),
    .acc_en       (acc_en),
    .acc_wr       (acc_wr),
    .acc_sel      (acc_sel),
    .pid_req      (pid_req),
    .cur_pid      (cur_pid),
    .new_pid      (new_pid),
    .inval_vld    (inval_vld),
    .pid_flush    (pid_flush),
    .pid_flush_id (pid_flush_id)
);

// File: tb/test_tlb_sreg_unit.sv
`timescale 1ns/1ps
module test_tlb_sreg_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bank_word;
    logic        acc_en, acc_wr;
    logic [3:0]  acc_sel;
    logic [31:0] wdata, rdata;
    logic        pid_req;
    logic [31:0] cur_pid, new_pid;
    logic        inval_vld;
    logic [31:0] inval_addr;
    logic        pid_flush;
    logic [7:0]  pid_flush_id;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model of the expected state
    logic [31:0] m_rf [4][16];
    logic [31:0] m_hi [2][4][16];
    logic [31:0] m_lo [2][4][16];

    always #10 clk = ~clk;   // 50 MHz

    tlb_sreg_unit i_tlb_sreg_unit (
        .clk(clk), .rst_n(rst_n), .bank_word(bank_word), .acc_en(acc_en),
        .acc_wr(acc_wr), .acc_sel(acc_sel), .wdata(wdata), .rdata(rdata),
        .pid_req(pid_req), .cur_pid(cur_pid), .new_pid(new_pid),
        .inval_vld(inval_vld), .inval_addr(inval_addr),
        .pid_flush(pid_flush), .pid_flush_id(pid_flush_id)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit mmu(input int b);
        return (b == 1) || (b == 2);
    endfunction

    task automatic do_write(input logic [31:0] bw, input int sel,
                            input logic [31:0] d, input string tag);
        int b, s, ix;
        logic        exp_v;
        logic [31:0] exp_a;
        b = int'(bw[1:0]);
        exp_v = 1'b0;
        exp_a = '0;
        if (mmu(b) && sel == 5) begin
            s  = int'(m_rf[b][4][5:4]);
            ix = int'(m_rf[b][4][3:0]);
            exp_v = m_lo[b-1][s][ix][3];
            exp_a = {m_hi[b-1][s][ix][31:13], 13'b0};
            m_lo[b-1][s][ix] = d;
            m_hi[b-1][s][ix] = m_rf[b][3];
        end
        if (mmu(b) && sel == 6) m_rf[b][3] = d;
        m_rf[b][sel] = d;
        @(negedge clk);
        bank_word = bw; acc_sel = 4'(sel); wdata = d; acc_wr = 1'b1; acc_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0;
        chk(inval_vld === exp_v, tag, {31'b0, inval_vld}, {31'b0, exp_v});
        if (exp_v) chk(inval_addr === exp_a, tag, inval_addr, exp_a);
    endtask

    task automatic do_read(input logic [31:0] bw, input int sel, input string tag);
        int b, s, ix;
        logic [31:0] exp;
        b = int'(bw[1:0]);
        exp = m_rf[b][sel];
        s = 0; ix = 0;
        if (mmu(b)) begin
            s  = int'(m_rf[b][4][5:4]);
            ix = int'(m_rf[b][4][3:0]);
            if (sel == 5) exp = m_lo[b-1][s][ix];
            if (sel == 6) exp = m_hi[b-1][s][ix];
        end
        @(negedge clk);
        bank_word = bw; acc_sel = 4'(sel); acc_wr = 1'b0; acc_en = 1'b1;
        #2;
        chk(rdata === exp, tag, rdata, exp);
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0;
        if (mmu(b)) begin
            m_rf[b][5] = m_lo[b-1][s][ix];
            m_rf[b][6] = m_hi[b-1][s][ix];
        end
    endtask

    task automatic do_pid(input logic [31:0] cp, input logic [31:0] np);
        bit diff;
        diff = cp[7:0] != np[7:0];
        @(negedge clk);
        cur_pid = cp; new_pid = np; pid_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pid_req = 1'b0;
        chk(pid_flush === diff, "R7 flush", {31'b0, pid_flush}, {31'b0, diff});
        if (diff) chk(pid_flush_id === cp[7:0], "R7 id", {24'b0, pid_flush_id}, {24'b0, cp[7:0]});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) m_rf[b][r] = '0;
        for (int a = 0; a < 2; a++) for (int s = 0; s < 4; s++)
            for (int i = 0; i < 16; i++) begin m_hi[a][s][i] = '0; m_lo[a][s][i] = '0; end
        rst_n = 1'b0; bank_word = '0; acc_en = 1'b0; acc_wr = 1'b0; acc_sel = '0;
        wdata = '0; pid_req = 1'b0; cur_pid = '0; new_pid = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(inval_vld === 1'b0, "R1 inval", {31'b0, inval_vld}, 32'd0);
        chk(pid_flush === 1'b0, "R1 flush", {31'b0, pid_flush}, 32'd0);
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 16; r++) do_read(32'(b), r, "R1 zero");

        // R2: bank from low bits only, banks separate
        do_write(32'hABCD_0000, 9, 32'h1111_2222, "R2 write");
        do_read(32'h0000_0000, 9, "R2 same bank");
        do_read(32'h5555_0003, 9, "R2 other bank");
        do_write(32'h1234_5673, 12, 32'h3333_4444, "R2 write b3");
        do_read(32'h0000_0003, 12, "R2 b3 read");
        do_read(32'h0000_0000, 12, "R2 b0 untouched");

        // R3: tlb-hi write copies into cause
        do_write(32'h0000_0001, 6, 32'hDEAD_A000, "R3 write hi");
        do_read(32'h0000_0001, 3, "R3 cause");
        // R8: plain bank leaves cause alone and commits nothing
        do_write(32'h0000_0000, 6, 32'hBEEF_0000, "R8 hi plain");
        do_read(32'h0000_0000, 3, "R8 cause unchanged");
        do_write(32'h0000_0003, 5, 32'h0000_0008, "R8 lo plain");

        // R4/R5: commit into empty entry, then replace a valid one
        do_write(32'h0000_0001, 4, 32'h0000_0025, "R4 tsel");
        do_write(32'h0000_0001, 6, 32'h1234_7FFF, "R4 cause");
        do_write(32'h0000_0001, 5, 32'h0000_0008, "R5 empty no inval");
        do_read(32'h0000_0001, 5, "R4 lo");
        do_read(32'h0000_0001, 6, "R4 hi from cause");
        do_write(32'h0000_0001, 6, 32'h0000_2000, "R4 cause2");
        do_write(32'h0000_0001, 5, 32'h0000_0000, "R5 valid replaced");
        do_write(32'h0000_0001, 5, 32'h0000_0008, "R5 invalid replaced");
        // R4: bank 2 uses its own array
        do_write(32'h0000_0002, 4, 32'h0000_0025, "R4 tsel b2");
        do_read(32'h0000_0002, 5, "R4 b2 separate");
        do_read(32'h0000_0002, 6, "R6 b2 hi");
        // R9: reads leave select and cause alone
        do_read(32'h0000_0001, 4, "R9 tsel kept");
        do_read(32'h0000_0001, 3, "R9 cause kept");

        // R7: PID compare on low bits
        do_pid(32'h0000_0042, 32'hFFFF_FF42);
        do_pid(32'h0000_0042, 32'h0000_0043);
        do_pid(32'hA5A5_A500, 32'h0000_00FF);

        // random mix
        for (int n = 0; n < 700; n++) begin
            int kind, sel, rs;
            logic [31:0] bw, d;
            kind = int'($urandom % 10);
            bw = $urandom;
            rs = int'($urandom % 6);
            case (rs)
                0: sel = 3;
                1: sel = 4;
                2: sel = 5;
                3: sel = 6;
                default: sel = int'($urandom % 16);
            endcase
            d = (sel == 4) ? ($urandom & 32'h3F) : $urandom;
            if (kind < 5) begin
                do_write(bw, sel, d, mmu(int'(bw[1:0])) ? "R5 random write" : "R8 random write");
            end else if (kind < 9) begin
                do_read(bw, sel, (mmu(int'(bw[1:0])) && (sel == 5 || sel == 6)) ? "R6 random read" : "R2 random read");
            end else begin
                logic [31:0] cp, np;
                cp = $urandom;
                np = $urandom[0] ? {$urandom[31:8], cp[7:0]} : $urandom;
                do_pid(cp, np);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule